// File: doc/BRIEF.md
# Clock Generator Configuration Target (SMBus Indexed Block Access)

This block is the serial control slave of a programmable clock generator. It sits on an SMBus segment as a target, decodes its own 7-bit address from two strap pins, and gives the host indexed block access to a bank of eight byte-wide configuration registers. A host write carries a start index, a byte count and then the data bytes. A host read first sets the index with a write, then issues a repeated start with the read address. The target replies with a length byte and then streams registers from that index upward until the host answers with a NACK.

The register bank holds the per-output enable bits, a test bit, the reference and feedback divider values for the PLL, and the read-back length. Each register has its own reset default and its own writable-bit mask. One register is read-only and shows the strap pins. Another is a fixed identity byte. The block combines the enable bits with an external enable pin to produce the per-output drive enables. It passes the source-select pin through to the output multiplexer.

SCL and SDA are brought into the system clock domain through synchronizers. SDA is driven as an open-drain pull-down enable. A start or stop seen at any point restarts or ends the current transfer.

Top module: `clkgen_smb_regs`

## Requirements
- R1: The target acknowledges only the address byte {5'b11011, strap_i[1], strap_i[0], rw}, where rw=0 means write and rw=1 means read. With strap_i=2'b10 this gives 0xDC and 0xDD. For any other address it leaves SDA released and drives nothing until the next start.
- R2: In a write, the byte after the address is the start index N and the next byte is a count X. The following X data bytes go to registers N, N+1, … in order. The target acknowledges every byte.
- R3: Data bytes sent after the count X is used up are acknowledged and change no register.
- R4: A read uses a write address, then index N, then a repeated start, then the read address. The target first returns {3'b000, reg7[4:0]}. It then returns register N, N+1, … for as long as the host acknowledges, and stops driving after a NACK.
- R5: Reset defaults: reg0=0x03, reg3=0x00, reg4=0x00, reg5=0x02, reg6=0x0A, reg7=0x07.
- R6: Writable bits: all 8 bits of reg0, reg3 and reg4; bits [3:0] of reg5; bits [5:0] of reg6; bits [4:0] of reg7. Bits outside these masks always read 0.
- R7: reg1 reads {1'b0, strap_i[1:0], 5'b00000} and reg2 reads 0x01. Writes to either are acknowledged and ignored.
- R8: A write to an index of 8 or above is acknowledged and ignored. A read at such an index returns 0x00.
- R9: out_en_o[i] is oe_pin_i AND reg0[i]. test_mode_o is reg0[7]. m_div_o is reg5[3:0] and n_div_o is reg6[5:0]. src_pll_o follows pll_sel_i (1 = PLL, 0 = reference).
- R10: Writing a register with the value it already holds causes no change at all on out_en_o.
- R11: A stop in the middle of a transfer ends it. A byte cut short by a stop is not written. The next start begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line (raw) |
| sda_i | input | 1 | SMBus data line (raw) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 2 | Address strap pins |
| oe_pin_i | input | 1 | Global output enable pin |
| pll_sel_i | input | 1 | Output source select pin |
| out_en_o | output | NUM_OUT | Per-output drive enable |
| src_pll_o | output | 1 | Output source: 1 PLL, 0 reference |
| test_mode_o | output | 1 | Test bit from reg0 |
| m_div_o | output | 4 | Reference divider value |
| n_div_o | output | 6 | Feedback divider value |

## Verification
A wrong index pointer or count shows up at the ports in the next register-mapped output that changes, or in the next read-back byte. A misplaced byte appears one byte slot away from where it belongs in the scoreboard stream. A bit-counter or acknowledge-phase fault shows up within one byte period as a missing ACK or a shifted data bit, because every read returns the length byte first. Stuck or glitching enables appear on out_en_o during the write that should leave them unchanged. This is visible while the transfer is still in progress, not only after the stop.

// File: rtl/clkgen_smb_pkg.sv
package clkgen_smb_pkg;

  localparam int REG_COUNT = 8;
  localparam int IDX_W     = 8;
  localparam int IDX_AW    = $clog2(REG_COUNT);

  localparam int R_OUTCTL = 0;
  localparam int R_STRAP  = 1;
  localparam int R_ID     = 2;
  localparam int R_MDIV   = 5;
  localparam int R_NDIV   = 6;
  localparam int R_RDLEN  = 7;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} bus_state_e;
  typedef enum logic [1:0] {P_ADDR, P_INDEX, P_COUNT, P_DATA} rx_phase_e;

  function automatic logic [7:0] wr_mask(int i);
    case (i)
      0, 3, 4: wr_mask = 8'hFF;
      5:       wr_mask = 8'h0F;
      6:       wr_mask = 8'h3F;
      7:       wr_mask = 8'h1F;
      default: wr_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_value(int i);
    case (i)
      0:       rst_value = 8'h03;
      5:       rst_value = 8'h02;
      6:       rst_value = 8'h0A;
      7:       rst_value = 8'h07;
      default: rst_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL stays high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/smb_target.sv
module smb_target
  import clkgen_smb_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       strap_i,
  input  logic [7:0]       rd_data_i,
  input  logic [4:0]       rd_len_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       wr_data_o
);
  bus_state_e state_q;
  rx_phase_e  phase_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_sh_q;
  logic [7:0] tx_sh_q;
  logic [7:0] remain_q;
  logic       ack_half_q, is_read_q, host_ack_q;
  logic [7:0] rx_byte, len_byte;
  logic       addr_hit;

  assign rx_byte  = {rx_sh_q, sda_s_i};
  assign addr_hit = (rx_byte[7:1] == {ADDR_PREFIX, strap_i});
  assign len_byte = {3'b000, rd_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      phase_q    <= P_ADDR;
      bit_cnt_q  <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      remain_q   <= '0;
      ack_half_q <= 1'b0;
      is_read_q  <= 1'b0;
      host_ack_q <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_data_o  <= '0;
      idx_o      <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (wr_en_o) idx_o <= idx_o + 1'b1;
      if (start_i) begin
        state_q   <= S_RX;
        phase_q   <= P_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q  <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          S_RX: if (scl_rise_i) begin
            rx_sh_q   <= rx_byte[6:0];
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == 3'd7) begin
              state_q    <= S_ACK;
              ack_half_q <= 1'b0;
              unique case (phase_q)
                P_ADDR: begin
                  if (addr_hit) begin
                    is_read_q <= rx_byte[0];
                    phase_q   <= P_INDEX;
                  end else begin
                    state_q <= S_IDLE;
                  end
                end
                P_INDEX: begin
                  idx_o   <= rx_byte;
                  phase_q <= P_COUNT;
                end
                P_COUNT: begin
                  remain_q <= rx_byte;
                  phase_q  <= P_DATA;
                end
                P_DATA: if (remain_q != 8'd0) begin
                  wr_en_o   <= 1'b1;
                  wr_data_o <= rx_byte;
                  remain_q  <= remain_q - 1'b1;
                end
              endcase
            end
          end
          S_ACK: if (scl_fall_i) begin
            if (!ack_half_q) begin
              sda_oe_o   <= 1'b1;
              ack_half_q <= 1'b1;
            end else begin
              bit_cnt_q <= '0;
              if (is_read_q) begin
                state_q  <= S_TX;
                tx_sh_q  <= len_byte;
                sda_oe_o <= ~len_byte[7];
              end else begin
                state_q  <= S_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          S_TX: if (scl_fall_i) begin
            if (bit_cnt_q == 3'd7) begin
              sda_oe_o   <= 1'b0;
              host_ack_q <= 1'b0;
              state_q    <= S_RACK;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
              tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
              sda_oe_o  <= ~tx_sh_q[6];
            end
          end
          S_RACK: begin
            if (scl_rise_i) host_ack_q <= ~sda_s_i;
            if (scl_fall_i) begin
              if (host_ack_q) begin
                tx_sh_q   <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[7];
                bit_cnt_q <= '0;
                idx_o     <= idx_o + 1'b1;
                state_q   <= S_TX;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: SDA drive only changes while SCL is low
  p_sda_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s_i));
  // R1: idle target never holds the line
  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !sda_oe_o);
  // R2: index advances one step per stored byte
  p_idx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (idx_o == $past(idx_o) + 8'd1));

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import clkgen_smb_pkg::*;
#(
  parameter int         NUM_OUT  = 2,
  parameter logic [7:0] ID_VALUE = 8'h01
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [1:0]         strap_i,
  output logic [7:0]         rd_data_o,
  output logic [NUM_OUT-1:0] en_bits_o,
  output logic               test_bit_o,
  output logic [3:0]         m_div_o,
  output logic [5:0]         n_div_o,
  output logic [4:0]         rd_len_o
);
  logic [7:0] regs_q [REG_COUNT];
  logic       in_range;

  assign in_range = (idx_i < IDX_W'(REG_COUNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= rst_value(i);
    end else if (wr_en_i && in_range) begin
      for (int i = 0; i < REG_COUNT; i++)
        if (idx_i[IDX_AW-1:0] == IDX_AW'(i)) regs_q[i] <= wr_data_i & wr_mask(i);
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (in_range) begin
      if (idx_i[IDX_AW-1:0] == IDX_AW'(R_STRAP))   rd_data_o = {1'b0, strap_i, 5'b00000};
      else if (idx_i[IDX_AW-1:0] == IDX_AW'(R_ID)) rd_data_o = ID_VALUE;
      else                                         rd_data_o = regs_q[idx_i[IDX_AW-1:0]];
    end
  end

  assign en_bits_o  = regs_q[R_OUTCTL][NUM_OUT-1:0];
  assign test_bit_o = regs_q[R_OUTCTL][7];
  assign m_div_o    = regs_q[R_MDIV][3:0];
  assign n_div_o    = regs_q[R_NDIV][5:0];
  assign rd_len_o   = regs_q[R_RDLEN][4:0];

  // R8: without a write strobe no register moves
  p_regs_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(regs_q[R_OUTCTL]) && $stable(regs_q[R_MDIV])
                  && $stable(regs_q[R_NDIV]) && $stable(regs_q[R_RDLEN])));

endmodule

// File: rtl/clkgen_smb_regs.sv
module clkgen_smb_regs
  import clkgen_smb_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b11011,
  parameter int         NUM_OUT     = 2,
  parameter logic [7:0] ID_VALUE    = 8'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [1:0]         strap_i,
  input  logic               oe_pin_i,
  input  logic               pll_sel_i,
  output logic [NUM_OUT-1:0] out_en_o,
  output logic               src_pll_o,
  output logic               test_mode_o,
  output logic [3:0]         m_div_o,
  output logic [5:0]         n_div_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] idx;
  logic [7:0] wr_data, rd_data;
  logic [4:0] rd_len;
  logic [NUM_OUT-1:0] en_bits;

  smb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_target #(.ADDR_PREFIX(ADDR_PREFIX)) u_tgt (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .strap_i,
    .rd_data_i(rd_data), .rd_len_i(rd_len),
    .sda_oe_o, .wr_en_o(wr_en), .idx_o(idx), .wr_data_o(wr_data)
  );

  cfg_regs #(.NUM_OUT(NUM_OUT), .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .idx_i(idx), .wr_data_i(wr_data),
    .strap_i, .rd_data_o(rd_data), .en_bits_o(en_bits), .test_bit_o(test_mode_o),
    .m_div_o, .n_div_o, .rd_len_o(rd_len)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out_en
    assign out_en_o[g] = oe_pin_i & en_bits[g];
  end

  assign src_pll_o = pll_sel_i;

  // R10: enables move only after a write or a pin change
  p_no_glitch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(oe_pin_i) && !$past(wr_en)) |-> $stable(out_en_o));

endmodule

// File: tb/test_clkgen_smb_regs.sv
module test_clkgen_smb_regs;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl = 1'b1, host_low = 1'b0;
  logic [1:0] strap = 2'b10;
  logic       oe_pin = 1'b1, pll_sel = 1'b1;
  logic       sda_oe, src_pll, test_mode;
  logic [1:0] out_en;
  logic [3:0] m_div;
  logic [5:0] n_div;
  wire        sda_bus = ~(host_low | sda_oe);

  clkgen_smb_regs i_clkgen_smb_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .oe_pin_i(oe_pin), .pll_sel_i(pll_sel), .out_en_o(out_en),
    .src_pll_o(src_pll), .test_mode_o(test_mode), .m_div_o(m_div), .n_div_o(n_div)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_val;
  event       rd_ev;
  logic       glitch_watch = 1'b0, glitch_seen = 1'b0;

  always @(out_en) if (glitch_watch) glitch_seen = 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      n_run++; n_fail++;
      $display("FAIL R4: unexpected byte actual 0x%0h expected none", rd_val);
    end else chk(tag_q.pop_front(), rd_val, exp_q.pop_front());
  end

  task automatic hw(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    host_low = 0; scl = 1; hw(Q); host_low = 1; hw(Q); scl = 0; hw(Q);
  endtask
  task automatic bus_rstart;
    host_low = 0; hw(Q); scl = 1; hw(Q); host_low = 1; hw(Q); scl = 0; hw(Q);
  endtask
  task automatic bus_stop;
    host_low = 1; hw(Q); scl = 1; hw(Q); host_low = 0; hw(2*Q);
  endtask

  task automatic send_bit(logic b);
    host_low = ~b; hw(Q); scl = 1; hw(2*Q); scl = 0; hw(Q);
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_low = 0; hw(Q); scl = 1; hw(Q); ack = ~sda_bus; hw(Q); scl = 0; hw(Q);
  endtask

  task automatic rd_byte(logic ack_it);
    logic [7:0] v = '0;
    host_low = 0;
    for (int i = 0; i < 8; i++) begin
      hw(Q); scl = 1; hw(Q); v = {v[6:0], sda_bus}; hw(Q); scl = 0; hw(Q);
    end
    host_low = ack_it; hw(Q); scl = 1; hw(2*Q); scl = 0; hw(Q); host_low = 0;
    rd_val = v; ->rd_ev; hw(1);
  endtask

  task automatic expect_byte(logic [7:0] b, string req);
    exp_q.push_back(b); tag_q.push_back(req);
  endtask

  task automatic blk_write(logic [7:0] idx, logic [7:0] cnt, logic [7:0] d[$], string req);
    logic a;
    bus_start;
    wr_byte(8'hDC, a); chk({req, " addr ack"}, a, 1);
    wr_byte(idx, a);   chk({req, " index ack"}, a, 1);
    wr_byte(cnt, a);   chk({req, " count ack"}, a, 1);
    foreach (d[k]) begin wr_byte(d[k], a); chk({req, " data ack"}, a, 1); end
    bus_stop;
  endtask

  task automatic blk_read(logic [7:0] idx, int nbytes, string req);
    logic a;
    bus_start;
    wr_byte(8'hDC, a); chk({req, " addr ack"}, a, 1);
    wr_byte(idx, a);   chk({req, " index ack"}, a, 1);
    bus_rstart;
    wr_byte(8'hDD, a); chk({req, " read addr ack"}, a, 1);
    for (int k = 0; k < nbytes; k++) rd_byte(k != nbytes - 1);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic a;
    hw(5); rst_n = 1; hw(5);
    // R5 R9 reset state
    chk("R5 out_en reset", out_en, 2'b11);
    chk("R5 m_div reset", m_div, 4'h2);
    chk("R5 n_div reset", n_div, 6'h0A);
    chk("R9 test_mode reset", test_mode, 0);
    chk("R9 src_pll", src_pll, 1);
    chk("R1 sda idle", sda_oe, 0);

    // R4 R5 R7 full read-back of defaults
    expect_byte(8'h07, "R4 length byte");
    expect_byte(8'h03, "R5 reg0"); expect_byte(8'h40, "R7 strap reg");
    expect_byte(8'h01, "R7 id reg"); expect_byte(8'h00, "R5 reg3");
    expect_byte(8'h00, "R5 reg4"); expect_byte(8'h02, "R5 reg5");
    expect_byte(8'h0A, "R5 reg6"); expect_byte(8'h07, "R5 reg7");
    blk_read(8'd0, 9, "R4");

    // R1 foreign address is not acknowledged
    bus_start; wr_byte(8'hD8, a); chk("R1 foreign addr nack", a, 0);
    chk("R1 sda released", sda_oe, 0); bus_stop;

    // R2 R6 block write with masks
    blk_write(8'd5, 8'd3, '{8'hF5, 8'hFF, 8'h13}, "R2");
    chk("R6 m_div masked", m_div, 4'h5);
    chk("R6 n_div masked", n_div, 6'h3F);
    expect_byte(8'h13, "R4 new length"); expect_byte(8'h05, "R6 reg5");
    expect_byte(8'h3F, "R6 reg6"); expect_byte(8'h13, "R6 reg7");
    blk_read(8'd5, 4, "R6");

    // R7 R3 R9 write into reg0/reg1, surplus byte dropped
    blk_write(8'd0, 8'd2, '{8'h81, 8'h22, 8'h55}, "R3");
    chk("R9 out_en from reg0", out_en, 2'b01);
    chk("R9 test_mode from reg0", test_mode, 1);
    blk_write(8'd3, 8'd1, '{8'hAA, 8'hBB}, "R3");
    expect_byte(8'h13, "R4 length"); expect_byte(8'h40, "R7 reg1 unchanged");
    expect_byte(8'h01, "R7 reg2 id"); expect_byte(8'hAA, "R2 reg3");
    expect_byte(8'h00, "R3 reg4 untouched");
    blk_read(8'd1, 5, "R3");

    // R8 out-of-range index
    blk_write(8'd9, 8'd1, '{8'h77}, "R8");
    expect_byte(8'h13, "R4 length"); expect_byte(8'h3F, "R8 reg6");
    expect_byte(8'h13, "R8 reg7"); expect_byte(8'h00, "R8 idx8");
    expect_byte(8'h00, "R8 idx9");
    blk_read(8'd6, 5, "R8");

    // R9 pins
    oe_pin = 0; pll_sel = 0; hw(2);
    chk("R9 oe pin low", out_en, 2'b00);
    chk("R9 src ref", src_pll, 0);
    oe_pin = 1; hw(2);
    chk("R9 oe pin high", out_en, 2'b01);

    // R10 same-value rewrite
    glitch_seen = 0; glitch_watch = 1;
    blk_write(8'd0, 8'd1, '{8'h81}, "R10");
    glitch_watch = 0;
    chk("R10 no out_en glitch", glitch_seen, 0);
    chk("R10 out_en kept", out_en, 2'b01);

    // R11 aborted transfers
    bus_start; wr_byte(8'hDC, a); wr_byte(8'd3, a); bus_stop;
    bus_start; wr_byte(8'hDC, a); wr_byte(8'd3, a); wr_byte(8'd1, a);
    for (int i = 7; i >= 4; i--) send_bit(1'b0);
    bus_stop;
    blk_write(8'd4, 8'd1, '{8'h5A}, "R11");
    expect_byte(8'h13, "R4 length"); expect_byte(8'hAA, "R11 reg3 kept");
    expect_byte(8'h5A, "R11 reg4 after restart");
    blk_read(8'd3, 3, "R11");

    hw(10);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule